// File: doc/BRIEF.md
# Local Bus Target Responder

This block is the response engine of an add-in card on a 486-class local bus. It watches each bus cycle start together with the verdict of an external address decoder. On a match it claims the cycle on an active-low claim pin and ends it with an active-low ready pin a fixed number of clocks later. For write cycles it also captures one word of write data. Two strapping inputs tell the card how fast the bus runs and whether zero-wait-state writes are in use. These two straps set the latest clock on which the claim may appear and the clock on which write data is taken.

Cycle numbering counts the clock in which `cyc_start` is high as cycle 1. The ready latency `RDY_DLY` (at least 1) places ready in cycle 1+`RDY_DLY`. The straps and the write/read direction are taken from cycle 1 and held for the rest of the cycle.

Captured data leaves on a valid-only stream: `cap_valid` is a one-clock strobe with `cap_data`. There is no back-pressure, so the consumer must take every strobe on the clock it appears. `cap_data` keeps its value between strobes.

Top module: `lbt_target`

## Requirements
- R1: On a cycle whose address does not match (`addr_hit` low while `cyc_start` is high), `claim_n` and `ready_n` stay high and no `cap_valid` strobe follows.
- R2: With `id_fast_bus` low (bus at or below 33 MHz), `claim_n` goes low combinationally in cycle 1 of a matching cycle and stays low through the ready cycle.
- R3: With `id_fast_bus` high (bus above 33 MHz), `claim_n` stays high in cycle 1 and is low from cycle 2 through the ready cycle.
- R4: `ready_n` is low for exactly one clock, in cycle 1+`RDY_DLY` of a matching cycle.
- R5: In the clock after the ready cycle, `claim_n` and `ready_n` are both high, unless a new matching cycle starts in that clock on a slow bus, in which case R2 applies.
- R6: With `id_no_zws` low, a matching write captures `wr_data` on the edge that ends the ready cycle, and `cap_valid` is high in the next clock.
- R7: With `id_no_zws` high, a matching write captures `wr_data` on the edge that ends the clock after the ready cycle, and `cap_valid` is high two clocks after the ready cycle and low in the clock between.
- R8: A matching read cycle (`cyc_write` low) produces no `cap_valid` strobe.
- R9: Changes on `id_fast_bus`, `id_no_zws` and `cyc_write` after cycle 1 do not alter the claim, ready or capture timing of the cycle in progress.
- R10: After reset, `claim_n` and `ready_n` are high and `cap_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | High in the first clock of a bus cycle |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle (taken in cycle 1) |
| addr_hit | input | 1 | Address decoder says this card owns the cycle |
| id_fast_bus | input | 1 | Speed strap: 1 = bus above 33 MHz, 0 = at or below |
| id_no_zws | input | 1 | Write strap: 1 = zero-wait-state writes not used |
| wr_data | input | DATA_W | Write data from the bus |
| claim_n | output | 1 | Active-low device claim |
| ready_n | output | 1 | Active-low cycle termination |
| cap_valid | output | 1 | One-clock strobe: `cap_data` holds a new write word |
| cap_data | output | DATA_W | Last captured write word |

## Verification
The deferred write capture of a cycle run with `id_no_zws` high falls in the same clock as cycle 1 of the next cycle when the two cycles run back to back. In that clock the new cycle's claim decision and strap sampling happen while the old word is being taken. The bench provokes this by starting random and directed cycles immediately after a ready cycle. It judges that the old cycle's strobe carries the data on the bus in that clock. It also judges that the new cycle's claim follows R2 or R3 for its own straps.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } lbt_state_e;

  typedef struct packed {
    logic fast_bus;
    logic no_zws;
    logic is_write;
  } lbt_cycle_t;
endpackage

// File: rtl/lbt_cycle_latch.sv
module lbt_cycle_latch
  import lbt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  lbt_cycle_t live,
  output lbt_cycle_t held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else if (load) begin
      held <= live;
    end
  end
endmodule

// File: rtl/lbt_claim_ctrl.sv
module lbt_claim_ctrl
  import lbt_pkg::*;
#(
  parameter int RDY_DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic addr_hit,
  input  logic fast_live,
  output logic accept,
  output logic term,
  output logic claim_n,
  output logic ready_n
);
  localparam int CNT_W = (RDY_DLY < 2) ? 1 : $clog2(RDY_DLY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RDY_DLY);

  lbt_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             busy;

  assign busy   = (state == ST_BUSY);
  assign accept = !busy && cyc_start && addr_hit;
  assign term   = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state <= ST_BUSY;
          cnt   <= CNT_W'(1);
        end
        ST_BUSY: if (cnt == LAST) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Slow bus: claim must be seen by the end of cycle 1, so it is driven
  // straight from the decode; fast bus waits for the registered claim.
  assign claim_n = !(busy || (accept && !fast_live));
  assign ready_n = !term;

  AST_NO_CLAIM_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cyc_start && addr_hit)) |-> (claim_n && ready_n)); // R1
  AST_SLOW_CLAIM_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !fast_live) |-> !claim_n); // R2
  AST_FAST_CLAIM_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fast_live) |-> claim_n); // R3
  AST_FAST_CLAIM_T2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !claim_n); // R3
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n |=> ready_n); // R4
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n |=> (claim_n || (cyc_start && addr_hit))); // R5
endmodule

// File: rtl/lbt_wdata_cap.sv
module lbt_wdata_cap
  import lbt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              term,
  input  lbt_cycle_t        cyc,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cap_valid,
  output logic [DATA_W-1:0] cap_data
);
  logic take_now;
  logic defer;

  assign take_now = term && cyc.is_write && !cyc.no_zws;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defer     <= 1'b0;
      cap_valid <= 1'b0;
      cap_data  <= '0;
    end else begin
      defer     <= term && cyc.is_write && cyc.no_zws;
      cap_valid <= take_now || defer;
      if (take_now || defer) begin
        cap_data <= wr_data;
      end
    end
  end

  AST_CAP_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_now && defer)); // R7
  AST_ZWS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    take_now |=> cap_valid); // R6
  AST_DEFER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (term && cyc.is_write && cyc.no_zws) |=> !cap_valid); // R7
  AST_READ_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !cyc.is_write) |=> !cap_valid); // R8
endmodule

// File: rtl/lbt_target.sv
module lbt_target
  import lbt_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RDY_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  input  logic              cyc_write,
  input  logic              addr_hit,
  input  logic              id_fast_bus,
  input  logic              id_no_zws,
  input  logic [DATA_W-1:0] wr_data,
  output logic              claim_n,
  output logic              ready_n,
  output logic              cap_valid,
  output logic [DATA_W-1:0] cap_data
);
  lbt_cycle_t live_cyc;
  lbt_cycle_t held_cyc;
  logic       accept;
  logic       term;

  assign live_cyc = '{fast_bus: id_fast_bus, no_zws: id_no_zws, is_write: cyc_write};

  lbt_cycle_latch u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .live (live_cyc),
    .held (held_cyc)
  );

  lbt_claim_ctrl #(.RDY_DLY(RDY_DLY)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_start(cyc_start),
    .addr_hit (addr_hit),
    .fast_live(id_fast_bus),
    .accept   (accept),
    .term     (term),
    .claim_n  (claim_n),
    .ready_n  (ready_n)
  );

  lbt_wdata_cap #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .term     (term),
    .cyc      (held_cyc),
    .wr_data  (wr_data),
    .cap_valid(cap_valid),
    .cap_data (cap_data)
  );

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_n && $past(!claim_n)) |-> $stable(held_cyc)); // R9
endmodule

// File: tb/test_lbt_target.sv
module test_lbt_target;
  localparam int DATA_W  = 32;
  localparam int RDY_DLY = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cyc_start = 1'b0;
  logic              cyc_write = 1'b0;
  logic              addr_hit = 1'b0;
  logic              id_fast_bus = 1'b0;
  logic              id_no_zws = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              claim_n;
  logic              ready_n;
  logic              cap_valid;
  logic [DATA_W-1:0] cap_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic              exp_v_cur = 1'b0, exp_v_n1 = 1'b0, exp_v_n2 = 1'b0;
  logic [DATA_W-1:0] exp_d_cur = '0, exp_d_n1 = '0, exp_d_n2 = '0;

  always #10 clk = ~clk;

  lbt_target #(.DATA_W(DATA_W), .RDY_DLY(RDY_DLY)) i_lbt_target (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_write(cyc_write),
    .addr_hit(addr_hit), .id_fast_bus(id_fast_bus), .id_no_zws(id_no_zws),
    .wr_data(wr_data), .claim_n(claim_n), .ready_n(ready_n),
    .cap_valid(cap_valid), .cap_data(cap_data)
  );

  function automatic logic f_claim_t1(logic hit, logic fast);
    return !(hit && !fast);
  endfunction

  function automatic logic f_ready(logic hit, int k);
    return !(hit && (k == 1 + RDY_DLY));
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    exp_v_cur = exp_v_n1; exp_d_cur = exp_d_n1;
    exp_v_n1  = exp_v_n2; exp_d_n1  = exp_d_n2;
    exp_v_n2  = 1'b0;     exp_d_n2  = '0;
  endtask

  task automatic look();
    #1;
    chk(cap_valid == exp_v_cur, "R6/R7/R8 cap_valid", cap_valid, exp_v_cur);
    if (exp_v_cur)
      chk(cap_data == exp_d_cur, "R6/R7 cap_data", cap_data, exp_d_cur);
  endtask

  // One bus cycle; b2b leaves the clock after ready for the next call.
  task automatic xact(logic hit, logic wr, logic fast, logic nozws,
                      logic [DATA_W-1:0] d0, logic [DATA_W-1:0] d1, bit b2b);
    step();
    cyc_start = 1'b1; addr_hit = hit; cyc_write = wr;
    id_fast_bus = fast; id_no_zws = nozws; wr_data = d0;
    look();
    chk(claim_n == f_claim_t1(hit, fast), fast ? "R3 claim cycle1" : "R2 claim cycle1",
        claim_n, f_claim_t1(hit, fast));
    chk(ready_n == 1'b1, "R4 ready cycle1", ready_n, 1);
    for (int k = 2; k <= 1 + RDY_DLY; k++) begin
      step();
      cyc_start = 1'b0; addr_hit = ~hit;
      id_fast_bus = ~fast; id_no_zws = ~nozws; cyc_write = ~wr; // R9 strap churn
      look();
      chk(claim_n == !hit, hit ? "R2/R3/R9 claim held" : "R1 no claim", claim_n, !hit);
      chk(ready_n == f_ready(hit, k), "R4 ready timing", ready_n, f_ready(hit, k));
    end
    if (hit && wr && !nozws) begin exp_v_n1 = 1'b1; exp_d_n1 = d0; end
    if (hit && wr &&  nozws) begin exp_v_n2 = 1'b1; exp_d_n2 = d1; end
    if (!b2b) begin
      step();
      cyc_start = 1'b0; addr_hit = 1'b0; wr_data = d1;
      look();
      chk(claim_n == 1'b1, "R5 claim released", claim_n, 1);
      chk(ready_n == 1'b1, "R5 ready released", ready_n, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] carry;
    bit prev_b2b;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(claim_n == 1'b1, "R10 claim reset", claim_n, 1);
    chk(ready_n == 1'b1, "R10 ready reset", ready_n, 1);
    chk(cap_valid == 1'b0, "R10 valid reset", cap_valid, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R6 R7: all four strap combinations, writes
    for (int s = 0; s < 4; s++)
      xact(1'b1, 1'b1, s[1], s[0], 32'hA000_0000 + s, 32'hB000_0000 + s, 1'b0);
    // R8: reads in all strap combinations
    for (int s = 0; s < 4; s++)
      xact(1'b1, 1'b0, s[1], s[0], 32'hC0 + s, 32'hD0 + s, 1'b0);
    // R1: misses
    xact(1'b0, 1'b1, 1'b0, 1'b0, 32'h11, 32'h22, 1'b0);
    xact(1'b0, 1'b1, 1'b1, 1'b1, 32'h33, 32'h44, 1'b0);
    // deferred capture meets next cycle start (R7 with R2, then R3)
    xact(1'b1, 1'b1, 1'b0, 1'b1, 32'h5555_0001, 32'h5555_0002, 1'b1);
    xact(1'b1, 1'b1, 1'b0, 1'b0, 32'h5555_0002, 32'h5555_0003, 1'b1);
    xact(1'b1, 1'b1, 1'b1, 1'b1, 32'h5555_0003, 32'h5555_0004, 1'b1);
    xact(1'b1, 1'b0, 1'b1, 1'b0, 32'h5555_0004, 32'h5555_0005, 1'b0);

    prev_b2b = 1'b0; carry = '0;
    for (int n = 0; n < 300; n++) begin
      logic [DATA_W-1:0] d0, d1;
      bit b2b;
      d0  = prev_b2b ? carry : $urandom;
      d1  = $urandom;
      b2b = ($urandom % 2) == 0;
      xact(($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 2, d0, d1, b2b);
      prev_b2b = b2b; carry = d1;
    end
    step(); cyc_start = 1'b0; addr_hit = 1'b0; wr_data = carry; look();
    repeat (3) begin step(); look(); end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule